// File: doc/BRIEF.md
# Memory Fence Issue Gate

The gate sits between an in-order micro-op dispatch stream and the execution side of an out-of-order core. Each dispatched micro-op carries a two-bit kind and a sequence tag. Compute micro-ops always pass straight through to the compute issue port. Loads and stores pass to their own issue ports. While a fence is pending, any later load or store is held at the dispatch handshake, and everything behind it stalls in order.

The gate counts loads that have issued but whose data has not returned, and stores that have issued but not yet retired. A fence that is accepted is placed in a small in-order queue. The fence at the head completes in the first cycle that finds both counts at zero. In that cycle the gate raises a one-cycle `fence_done` with the fence's tag and lets memory traffic through again, unless another fence is still queued behind it. The memory type of the target region has no effect: every load and store is treated the same way. Address checks and cache behaviour are not part of this block.

Top module: `fence_gate`

## Requirements
- R1: When reset is released, both outstanding counts are zero and no fence is pending. A load or store offered in the first cycle after reset is accepted, and `fence_done` is low.
- R2: The kind encoding is 00 compute, 01 load, 10 store, 11 fence. A valid compute micro-op is always accepted, whatever fences are pending. It appears on `cmp_issue_valid` in the same cycle, with its tag on `cmp_issue_tag`.
- R3: When no fence is pending and the relevant count is below its limit, a valid load or store is accepted. It appears in the same cycle on `ld_issue_valid` or `st_issue_valid`, with its tag on the matching tag output.
- R4: From the cycle after a fence is accepted until that fence's `fence_done` cycle, every load and store offered sees `disp_ready` low and is not issued.
- R5: `fence_done` is high in the first cycle in which a fence is at the head of the queue and both outstanding counts are zero. The counts reflect issue, `ld_data_done` and `st_retired` events up to the previous clock edge. A fence accepted with nothing outstanding therefore completes in the next cycle.
- R6: Each accepted fence produces exactly one `fence_done` pulse, carrying its own tag on `fence_done_tag`. Fences complete in acceptance order, at most one per cycle.
- R7: In the `fence_done` cycle of the last queued fence, a load or store offered on dispatch is accepted and issued in that same cycle.
- R8: A load is refused while `MAX_LD` loads are outstanding. A store is refused while `MAX_ST` stores are outstanding.
- R9: A fence is refused while the fence queue holds `FENCE_DEPTH` entries.
- R10: `ld_data_done` lowers only the load count and `st_retired` lowers only the store count. A fence therefore keeps waiting while either count is non-zero.
- R11: When `disp_valid` is low, or when `disp_ready` is low, no issue output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch micro-op present |
| disp_kind | input | 2 | Micro-op kind (00 compute, 01 load, 10 store, 11 fence) |
| disp_tag | input | TAG_W | Sequence tag of the micro-op |
| disp_ready | output | 1 | Gate accepts the micro-op this cycle |
| cmp_issue_valid | output | 1 | Compute micro-op issued |
| cmp_issue_tag | output | TAG_W | Tag of the issued compute micro-op |
| ld_issue_valid | output | 1 | Load issued to the load buffer |
| ld_issue_tag | output | TAG_W | Tag of the issued load |
| st_issue_valid | output | 1 | Store issued to the store buffer |
| st_issue_tag | output | TAG_W | Tag of the issued store |
| ld_data_done | input | 1 | One older load has returned its data |
| st_retired | input | 1 | One older store has retired |
| fence_done | output | 1 | The head fence has completed this cycle |
| fence_done_tag | output | TAG_W | Tag of the completing fence |

## Verification
The bench builds the gate with `MAX_LD` and `MAX_ST` set to 3, `FENCE_DEPTH` set to 2 and `TAG_W` set to 6. With these small values, slow completion streams drive both outstanding counts to their limits, and bursts of fences fill the queue, so the refusal paths of R8 and R9 occur often. Two queued fences complete on consecutive cycles. The release of memory traffic in the completion cycle, and a fence accepted with nothing outstanding, both come up many times over the run.

// File: rtl/fence_gate_pkg.sv
package fence_gate_pkg;

   typedef enum logic [1:0] {
      KIND_CMP   = 2'b00,
      KIND_LOAD  = 2'b01,
      KIND_STORE = 2'b10,
      KIND_FENCE = 2'b11
   } uop_kind_e;

endpackage

// File: rtl/fence_gate_ocnt.sv
module fence_gate_ocnt #(
   parameter int unsigned MAX = 16,
   parameter int unsigned W   = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         dec,
   output logic         full,
   output logic         zero
);

   if (MAX < 1) begin : g_bad_max
      $error("fence_gate_ocnt: MAX must be at least 1");
   end
   if (W != $clog2(MAX + 1)) begin : g_bad_w
      $error("fence_gate_ocnt: W does not match MAX");
   end

   logic [W-1:0] cnt_q;
   logic         dec_ok;
   logic         inc_ok;

   assign dec_ok = dec && (cnt_q != '0);
   assign inc_ok = inc && (cnt_q != W'(MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc_ok && !dec_ok) begin
         cnt_q <= cnt_q + W'(1);
      end else if (dec_ok && !inc_ok) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign full = (cnt_q == W'(MAX));
   assign zero = (cnt_q == '0);

endmodule

// File: rtl/fence_gate_tagq.sv
module fence_gate_tagq #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 8,
   parameter int unsigned CW    = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_tag,
   input  logic          pop,
   output logic [W-1:0]  head_tag,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("fence_gate_tagq: DEPTH must be at least 1");
   end
   if (CW != $clog2(DEPTH + 1)) begin : g_bad_cw
      $error("fence_gate_tagq: CW does not match DEPTH");
   end

   if (DEPTH == 1) begin : g_single
      logic         held_q;
      logic [W-1:0] tag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_q <= 1'b0;
         end else if (push) begin
            held_q <= 1'b1;
         end else if (pop) begin
            held_q <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (push) begin
            tag_q <= push_tag;
         end
      end

      assign head_tag = tag_q;
      assign empty    = !held_q;
      assign full     = held_q;
      assign count    = CW'(held_q);
   end else begin : g_ring
      localparam int unsigned PW = $clog2(DEPTH);

      logic [W-1:0]  slot_q [DEPTH];
      logic [PW-1:0] wr_q;
      logic [PW-1:0] rd_q;
      logic [CW-1:0] cnt_q;
      logic          do_push;
      logic          do_pop;

      assign do_push = push && (cnt_q != CW'(DEPTH));
      assign do_pop  = pop && (cnt_q != '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) begin
               wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
            end
            if (do_pop) begin
               rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
            end
            if (do_push && !do_pop) begin
               cnt_q <= cnt_q + CW'(1);
            end else if (do_pop && !do_push) begin
               cnt_q <= cnt_q - CW'(1);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) begin
            slot_q[wr_q] <= push_tag;
         end
      end

      assign head_tag = slot_q[rd_q];
      assign empty    = (cnt_q == '0);
      assign full     = (cnt_q == CW'(DEPTH));
      assign count    = cnt_q;
   end

endmodule

// File: rtl/fence_gate.sv
module fence_gate
   import fence_gate_pkg::*;
#(
   parameter int unsigned TAG_W       = 8,
   parameter int unsigned MAX_LD      = 16,
   parameter int unsigned MAX_ST      = 16,
   parameter int unsigned FENCE_DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_valid,
   input  logic [1:0]       disp_kind,
   input  logic [TAG_W-1:0] disp_tag,
   output logic             disp_ready,
   output logic             cmp_issue_valid,
   output logic [TAG_W-1:0] cmp_issue_tag,
   output logic             ld_issue_valid,
   output logic [TAG_W-1:0] ld_issue_tag,
   output logic             st_issue_valid,
   output logic [TAG_W-1:0] st_issue_tag,
   input  logic             ld_data_done,
   input  logic             st_retired,
   output logic             fence_done,
   output logic [TAG_W-1:0] fence_done_tag
);

   localparam int unsigned LD_W = $clog2(MAX_LD + 1);
   localparam int unsigned ST_W = $clog2(MAX_ST + 1);
   localparam int unsigned FQ_W = $clog2(FENCE_DEPTH + 1);

   if (TAG_W < 1) begin : g_bad_tag
      $error("fence_gate: TAG_W must be at least 1");
   end

   logic             ld_full, ld_zero;
   logic             st_full, st_zero;
   logic             fq_empty, fq_full;
   logic [FQ_W-1:0]  fq_count;
   logic [TAG_W-1:0] fq_head;
   logic             mem_hold;
   logic             kind_cmp, kind_ld, kind_st, kind_fence;
   logic             take;

   // decode the dispatched kind
   always_comb begin
      kind_cmp   = 1'b0;
      kind_ld    = 1'b0;
      kind_st    = 1'b0;
      kind_fence = 1'b0;
      unique case (uop_kind_e'(disp_kind))
         KIND_CMP:   kind_cmp   = 1'b1;
         KIND_LOAD:  kind_ld    = 1'b1;
         KIND_STORE: kind_st    = 1'b1;
         KIND_FENCE: kind_fence = 1'b1;
      endcase
   end

   // head fence completes once nothing older is in flight
   assign fence_done     = !fq_empty && ld_zero && st_zero;
   assign fence_done_tag = fq_head;

   // memory held while any fence remains after this cycle's completion
   assign mem_hold = !fq_empty && !((fq_count == FQ_W'(1)) && fence_done);

   always_comb begin
      disp_ready = 1'b1;
      if (kind_ld) begin
         disp_ready = !mem_hold && !ld_full;
      end else if (kind_st) begin
         disp_ready = !mem_hold && !st_full;
      end else if (kind_fence) begin
         disp_ready = !fq_full;
      end
   end

   assign take = disp_valid && disp_ready;

   assign cmp_issue_valid = take && kind_cmp;
   assign ld_issue_valid  = take && kind_ld;
   assign st_issue_valid  = take && kind_st;
   assign cmp_issue_tag   = disp_tag;
   assign ld_issue_tag    = disp_tag;
   assign st_issue_tag    = disp_tag;

   fence_gate_ocnt #(
      .MAX (MAX_LD),
      .W   (LD_W)
   ) u_ld_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ld_issue_valid),
      .dec   (ld_data_done),
      .full  (ld_full),
      .zero  (ld_zero)
   );

   fence_gate_ocnt #(
      .MAX (MAX_ST),
      .W   (ST_W)
   ) u_st_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (st_issue_valid),
      .dec   (st_retired),
      .full  (st_full),
      .zero  (st_zero)
   );

   fence_gate_tagq #(
      .DEPTH (FENCE_DEPTH),
      .W     (TAG_W),
      .CW    (FQ_W)
   ) u_fence_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (take && kind_fence),
      .push_tag (disp_tag),
      .pop      (fence_done),
      .head_tag (fq_head),
      .empty    (fq_empty),
      .full     (fq_full),
      .count    (fq_count)
   );

endmodule

// File: rtl/fence_gate_chk.sv
module fence_gate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       disp_valid,
   input logic [1:0] disp_kind,
   input logic       disp_ready,
   input logic       cmp_issue_valid,
   input logic       ld_issue_valid,
   input logic       st_issue_valid,
   input logic       ld_data_done,
   input logic       st_retired,
   input logic       fence_done
);

   int ck_ld;
   int ck_st;
   int ck_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_ld   <= 0;
         ck_st   <= 0;
         ck_pend <= 0;
      end else begin
         ck_ld   <= ck_ld + (ld_issue_valid ? 1 : 0) - ((ld_data_done && ck_ld > 0) ? 1 : 0);
         ck_st   <= ck_st + (st_issue_valid ? 1 : 0) - ((st_retired && ck_st > 0) ? 1 : 0);
         ck_pend <= ck_pend + ((disp_valid && disp_ready && disp_kind == 2'b11) ? 1 : 0)
                            - (fence_done ? 1 : 0);
      end
   end

   assert_cmp_accepted_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_kind == 2'b00) |-> (disp_ready && cmp_issue_valid));

   assert_load_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_issue_valid |-> (ck_pend == 0 || (ck_pend == 1 && fence_done)));

   assert_store_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      st_issue_valid |-> (ck_pend == 0 || (ck_pend == 1 && fence_done)));

   assert_done_drained_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done |-> (ck_ld == 0 && ck_st == 0));

   assert_done_has_fence_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fence_done |-> (ck_pend > 0));

   assert_single_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({cmp_issue_valid, ld_issue_valid, st_issue_valid}) <= 1);

   assert_idle_no_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!disp_valid || !disp_ready) |-> !(cmp_issue_valid || ld_issue_valid || st_issue_valid));

endmodule

bind fence_gate fence_gate_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .disp_valid      (disp_valid),
   .disp_kind       (disp_kind),
   .disp_ready      (disp_ready),
   .cmp_issue_valid (cmp_issue_valid),
   .ld_issue_valid  (ld_issue_valid),
   .st_issue_valid  (st_issue_valid),
   .ld_data_done    (ld_data_done),
   .st_retired      (st_retired),
   .fence_done      (fence_done)
);

// File: tb/test_fence_gate.sv
module test_fence_gate;

   localparam int CLK_P = 10;
   localparam int TW    = 6;
   localparam int MLD   = 3;
   localparam int MST   = 3;
   localparam int FDEP  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          disp_valid = 1'b0;
   logic [1:0]    disp_kind = 2'b00;
   logic [TW-1:0] disp_tag = '0;
   logic          disp_ready;
   logic          cmp_issue_valid, ld_issue_valid, st_issue_valid;
   logic [TW-1:0] cmp_issue_tag, ld_issue_tag, st_issue_tag;
   logic          ld_data_done = 1'b0;
   logic          st_retired = 1'b0;
   logic          fence_done;
   logic [TW-1:0] fence_done_tag;

   int n_vec  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // reference model state
   int            m_ld, m_st;
   logic [TW-1:0] m_fq[$];
   int            since_rst;
   int            cyc = 0;

   fence_gate #(
      .TAG_W       (TW),
      .MAX_LD      (MLD),
      .MAX_ST      (MST),
      .FENCE_DEPTH (FDEP)
   ) i_fence_gate (
      .clk             (clk),
      .rst_n           (rst_n),
      .disp_valid      (disp_valid),
      .disp_kind       (disp_kind),
      .disp_tag        (disp_tag),
      .disp_ready      (disp_ready),
      .cmp_issue_valid (cmp_issue_valid),
      .cmp_issue_tag   (cmp_issue_tag),
      .ld_issue_valid  (ld_issue_valid),
      .ld_issue_tag    (ld_issue_tag),
      .st_issue_valid  (st_issue_valid),
      .st_issue_tag    (st_issue_tag),
      .ld_data_done    (ld_data_done),
      .st_retired      (st_retired),
      .fence_done      (fence_done),
      .fence_done_tag  (fence_done_tag)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", rq, what, act, exp, cyc);
      end
   endtask

   task automatic model_reset();
      m_ld = 0;
      m_st = 0;
      m_fq.delete();
      since_rst = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n        = 1'b0;
      disp_valid   = 1'b0;
      ld_data_done = 1'b0;
      st_retired   = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic step(input int p_valid, input int p_fence, input int p_mem, input int p_done);
      bit   e_done, e_hold, e_ready, last_rel;
      int   r;
      string rq, rqd;
      @(negedge clk);
      cyc++;
      disp_valid = (($urandom % 100) < p_valid);
      r = $urandom % 100;
      if (r < p_fence)              disp_kind = 2'b11;
      else if (r < p_fence + p_mem) disp_kind = ($urandom % 2) ? 2'b01 : 2'b10;
      else                          disp_kind = 2'b00;
      disp_tag     = TW'(cyc);
      ld_data_done = (m_ld > 0) && (($urandom % 100) < p_done);
      st_retired   = (m_st > 0) && (($urandom % 100) < p_done);
      #(CLK_P/4);

      // expectations from the requirements
      e_done   = (m_fq.size() > 0) && (m_ld == 0) && (m_st == 0);
      last_rel = e_done && (m_fq.size() == 1);
      e_hold   = (m_fq.size() > 0) && !last_rel;
      case (disp_kind)
         2'b00: begin e_ready = 1'b1; rq = "R2"; end
         2'b01: begin
            e_ready = !e_hold && (m_ld < MLD);
            rq = e_hold ? "R4" : (m_ld >= MLD) ? "R8" : last_rel ? "R7" : "R3";
         end
         2'b10: begin
            e_ready = !e_hold && (m_st < MST);
            rq = e_hold ? "R4" : (m_st >= MST) ? "R8" : last_rel ? "R7" : "R3";
         end
         default: begin e_ready = (m_fq.size() < FDEP); rq = "R9"; end
      endcase
      if (!disp_valid) rq = "R11";
      rqd = ((m_ld == 0) != (m_st == 0)) ? "R10" : "R5";
      if (since_rst < 2) begin rq = "R1"; rqd = "R1"; end

      chk(rq, "disp_ready", int'(disp_ready), int'(e_ready));
      chk(rq, "cmp_issue_valid", int'(cmp_issue_valid), int'(disp_valid && disp_kind == 2'b00));
      chk(rq, "ld_issue_valid", int'(ld_issue_valid), int'(disp_valid && e_ready && disp_kind == 2'b01));
      chk(rq, "st_issue_valid", int'(st_issue_valid), int'(disp_valid && e_ready && disp_kind == 2'b10));
      if (cmp_issue_valid) chk("R2", "cmp_issue_tag", int'(cmp_issue_tag), int'(disp_tag));
      if (ld_issue_valid)  chk("R3", "ld_issue_tag", int'(ld_issue_tag), int'(disp_tag));
      if (st_issue_valid)  chk("R3", "st_issue_tag", int'(st_issue_tag), int'(disp_tag));
      chk(rqd, "fence_done", int'(fence_done), int'(e_done));
      if (e_done) chk("R6", "fence_done_tag", int'(fence_done_tag), int'(m_fq[0]));

      // advance the model past the coming edge
      if (e_done) void'(m_fq.pop_front());
      if (disp_valid && e_ready) begin
         if (disp_kind == 2'b11) m_fq.push_back(disp_tag);
         if (disp_kind == 2'b01) m_ld++;
         if (disp_kind == 2'b10) m_st++;
      end
      if (ld_data_done) m_ld--;
      if (st_retired)   m_st--;
      since_rst++;
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: memory heavy, slow completions, no fences
      for (int i = 0; i < 300; i++) step(90, 0, 70, 15);
      // R4 R5 R6 R7: fences mixed with steady completions
      for (int i = 0; i < 400; i++) step(80, 15, 50, 40);
      // R9: fence bursts with slow draining
      for (int i = 0; i < 400; i++) step(90, 35, 40, 5);
      // R1: reset in the middle of traffic
      do_reset();
      for (int i = 0; i < 600; i++) step(70, 10, 50, 30);
      for (int i = 0; i < 300; i++) step(95, 25, 45, 60);
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule